// File: doc/BRIEF.md
# Masked Event Interrupt Unit

This block gathers event flags into an 8-bit pending register and drives an active-low interrupt line. The line is low while any pending flag is also enabled in an 8-bit enable mask. Three sources set flags. The first is a periodic tick strobe. The second is a device reply, which arrives with up to 16 data bytes and a length. The third is an autopoll reply, which is the same kind of payload but produced by background polling. A reply's bytes are kept in a buffer until the host collects them.

The host talks to the block through a command port. Each command is an opcode, an argument count and one argument byte. There are two commands. Set-mask replaces the enable mask. Acknowledge returns a byte stream and clears pending flags. The acknowledge reply has a priority order:
- If a device reply is waiting, the stream is a status byte followed by the buffered reply bytes, and only the reply-related flags are cleared.
- Otherwise the stream is a single byte holding the whole pending register, and the register is cleared.

The block also times the autopoll requests. It pulses a request output at a fixed interval while a 16-bit poll mask is nonzero. The poll mask is passed on to the external poller. Transport, device polling and the time base are outside the block.

Top module: `evt_irq_unit`

## Requirements
- R1: `irq_n_o` is low exactly when (pending AND enable mask) is nonzero. It reflects a pending or mask change in the cycle after the clock edge that made the change.
- R2: After reset the pending register is 0x00, the enable mask is 0x09 (reply flag and tick flag), no reply stream is active and autopoll is off.
- R3: A one-cycle `tick_i` pulse sets pending bit 3 (tick flag).
- R4: A device reply (`rply_vld_i` with `rply_auto_i`=0) sets pending bit 0 (reply flag) and stores its bytes in the buffer. Byte k is taken from `rply_data_i[8k+7:8k]`. A length above 16 is stored as 16.
- R5: An autopoll reply (`rply_vld_i` with `rply_auto_i`=1) is taken only when bit 0 is clear and the length is nonzero. It then sets bit 0 and bit 2 (autopoll flag) and stores its bytes. A rejected reply leaves the pending register and the buffer unchanged.
- R6: Opcode 0x20 is acknowledge and is valid only with an argument count of 0. Opcode 0x21 is set-mask and is valid only with an argument count of 1; it loads `cmd_arg_i` into the enable mask. A command with a wrong count or an unknown opcode has no effect.
- R7: An acknowledge issued while bit 0 is set streams (pending AND 0x05) first, then the buffered bytes in index order. It clears bits 0 and 2 and empties the buffer. Other pending bits are kept.
- R8: An acknowledge issued while bit 0 is clear streams one byte equal to the pending register and clears the register to 0x00.
- R9: A flag set in the same cycle as an acknowledge that clears it stays set. A reply arriving in that cycle also replaces the buffer contents.
- R10: The first stream byte appears in the cycle after the acknowledge is taken, and one byte follows per cycle. `rsp_last_o` marks the final byte. Commands presented while `rsp_vld_o` is high are ignored.
- R11: While the poll mask is nonzero, `poll_req_o` pulses once every POLL_CYCLES cycles. The first pulse comes POLL_CYCLES cycles after a write that changes the mask. Writing zero stops the pulses. Rewriting the current value leaves the interval undisturbed. A pulse is suppressed while bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Periodic tick strobe |
| rply_vld_i | input | 1 | Reply strobe |
| rply_auto_i | input | 1 | 1 = autopoll reply, 0 = device reply |
| rply_len_i | input | LEN_W | Reply byte count |
| rply_data_i | input | DEPTH*8 | Reply bytes, byte 0 in the low bits |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_op_i | input | 8 | Command opcode |
| cmd_argc_i | input | 2 | Argument byte count |
| cmd_arg_i | input | 8 | Argument byte |
| poll_mask_wr_i | input | 1 | Poll mask write strobe |
| poll_mask_i | input | 16 | New poll mask |
| irq_n_o | output | 1 | Active-low interrupt |
| rsp_vld_o | output | 1 | Reply stream byte valid |
| rsp_data_o | output | 8 | Reply stream byte |
| rsp_last_o | output | 1 | Final byte of the stream |
| poll_req_o | output | 1 | Autopoll request pulse |
| poll_mask_o | output | 16 | Current poll mask |

## Verification
A wrong pending bit can only be seen in two places: the interrupt line, one cycle after the bad update, and the next acknowledge stream. The bench therefore pairs every event pattern with a check of the line and a full stream comparison, including collisions where a set and an acknowledge clear hit the same edge. Buffer or length corruption appears as wrong, missing or extra stream bytes, or as `rsp_last_o` on the wrong byte. A fault in the poll counter appears as a changed pulse interval, which is measured in cycles against POLL_CYCLES.

// File: rtl/evt_pkg.sv
// Shared constants for the masked event interrupt unit: flag positions,
// command opcodes and reset values. Assumes an 8-bit flag space.
package evt_pkg;
    localparam int BIT_INPUT = 0;
    localparam int BIT_AUTO  = 2;
    localparam int BIT_TICK  = 3;

    localparam logic [7:0] OP_ACK    = 8'h20;
    localparam logic [7:0] OP_MASK   = 8'h21;
    localparam logic [7:0] MASK_RST  = 8'h09;
    localparam logic [7:0] INPUT_GRP = 8'h05;
endpackage

// File: rtl/evt_pending.sv
// Pending flag register and reply buffer.
// Sets flags from the tick and reply strobes, takes or rejects replies, and
// applies the acknowledge clear with set-over-clear priority.
// Assumes ack_i is already qualified (valid opcode, length, not busy).
module evt_pending import evt_pkg::*; #(
    parameter int DEPTH = 16,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               rply_vld_i,
    input  logic               rply_auto_i,
    input  logic [LEN_W-1:0]   rply_len_i,
    input  logic [DEPTH*8-1:0] rply_data_i,
    input  logic               ack_i,
    output logic [7:0]         pend_o,
    output logic [DEPTH*8-1:0] rbuf_o,
    output logic [LEN_W-1:0]   len_o
);
    logic [7:0]         pend_q;
    logic [DEPTH*8-1:0] rbuf_q;
    logic [LEN_W-1:0]   len_q;
    logic               acc_dir, acc_auto, take;
    logic [7:0]         set_v, clr_v;
    logic [LEN_W-1:0]   len_in;

    // Decide which reply is taken and build the set and clear vectors.
    always_comb begin
        acc_dir  = rply_vld_i && !rply_auto_i;
        acc_auto = rply_vld_i && rply_auto_i && !pend_q[BIT_INPUT] && (rply_len_i != '0);
        take     = acc_dir || acc_auto;
        len_in   = (rply_len_i > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : rply_len_i;
        set_v    = 8'h00;
        if (tick_i)   set_v[BIT_TICK]  = 1'b1;
        if (take)     set_v[BIT_INPUT] = 1'b1;
        if (acc_auto) set_v[BIT_AUTO]  = 1'b1;
        if (!ack_i)                 clr_v = 8'h00;
        else if (pend_q[BIT_INPUT]) clr_v = INPUT_GRP;
        else                        clr_v = 8'hFF;
    end

    // Pending register: clear first, then set, so a new event survives.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 8'h00;
        else        pend_q <= (pend_q & ~clr_v) | set_v;
    end

    // Reply buffer: a new reply wins over the acknowledge drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf_q <= '0;
            len_q  <= '0;
        end else if (take) begin
            rbuf_q <= rply_data_i;
            len_q  <= len_in;
        end else if (ack_i && pend_q[BIT_INPUT]) begin
            len_q  <= '0;
        end
    end

    assign pend_o = pend_q;
    assign rbuf_o = rbuf_q;
    assign len_o  = len_q;

    // R3
    tick_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> pend_q[BIT_TICK]);
    // R5
    auto_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rply_vld_i && rply_auto_i && pend_q[BIT_INPUT] && !ack_i) |=> $stable(len_q));
    // R7
    ack_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && pend_q[BIT_INPUT] && !rply_vld_i) |=>
        (len_q == '0 && !pend_q[BIT_INPUT] && !pend_q[BIT_AUTO]));
    // R8
    ack_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !pend_q[BIT_INPUT] && !tick_i && !rply_vld_i) |=> (pend_q == 8'h00));
endmodule

// File: rtl/evt_poll_timer.sv
// Autopoll interval timer.
// Holds the poll mask and pulses a request every POLL_CYCLES cycles while the
// mask is nonzero. Only a write that changes the mask restarts the count.
// Assumes hold_i is high while a reply is waiting to be collected.
module evt_poll_timer #(
    parameter int POLL_CYCLES = 7_500_000,
    localparam int CNT_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mask_wr_i,
    input  logic [15:0] mask_i,
    input  logic        hold_i,
    output logic        poll_req_o,
    output logic [15:0] mask_o
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(POLL_CYCLES - 1);

    logic [15:0]      mask_q;
    logic [CNT_W-1:0] cnt_q;
    logic             req_q;

    // Mask update, interval count and request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 16'h0000;
            cnt_q  <= '0;
            req_q  <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (mask_wr_i && mask_i != mask_q) begin
                mask_q <= mask_i;
                cnt_q  <= '0;
            end else if (mask_q != 16'h0000) begin
                if (cnt_q == LIM) begin
                    cnt_q <= '0;
                    req_q <= !hold_i;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign poll_req_o = req_q;
    assign mask_o     = mask_q;

    // R11
    poll_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr_i && mask_i == 16'h0000) |=> !poll_req_o);
    // R11
    poll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !poll_req_o);
endmodule

// File: rtl/evt_rsp_stream.sv
// Reply stream shifter.
// Takes a snapshot of up to NBYTES bytes and a count, then emits one byte per
// cycle starting at the low byte. Assumes load_i only arrives while idle.
module evt_rsp_stream #(
    parameter int NBYTES = 17,
    localparam int CNT_W = $clog2(NBYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [NBYTES*8-1:0] load_data_i,
    input  logic [CNT_W-1:0]    load_cnt_i,
    output logic                vld_o,
    output logic [7:0]          data_o,
    output logic                last_o
);
    logic [NBYTES*8-1:0] sh_q;
    logic [CNT_W-1:0]    cnt_q;

    // Load a snapshot or advance one byte per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            sh_q  <= load_data_i;
            cnt_q <= load_cnt_i;
        end else if (cnt_q != '0) begin
            sh_q  <= sh_q >> 8;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign vld_o  = (cnt_q != '0);
    assign data_o = sh_q[7:0];
    assign last_o = (cnt_q == CNT_W'(1));

    // R10
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !vld_o);
    // R10
    stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && last_o) |=> !vld_o);
endmodule

// File: rtl/evt_irq_unit.sv
// Masked event interrupt unit, top level.
// Decodes commands, holds the enable mask, forms the acknowledge snapshot and
// drives the active-low interrupt. Assumes single-cycle strobes on all inputs.
module evt_irq_unit import evt_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int POLL_CYCLES = 7_500_000,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               rply_vld_i,
    input  logic               rply_auto_i,
    input  logic [LEN_W-1:0]   rply_len_i,
    input  logic [DEPTH*8-1:0] rply_data_i,
    input  logic               cmd_vld_i,
    input  logic [7:0]         cmd_op_i,
    input  logic [1:0]         cmd_argc_i,
    input  logic [7:0]         cmd_arg_i,
    input  logic               poll_mask_wr_i,
    input  logic [15:0]        poll_mask_i,
    output logic               irq_n_o,
    output logic               rsp_vld_o,
    output logic [7:0]         rsp_data_o,
    output logic               rsp_last_o,
    output logic               poll_req_o,
    output logic [15:0]        poll_mask_o
);
    localparam int NBYTES = DEPTH + 1;
    localparam int SCNT_W = $clog2(NBYTES + 1);

    logic [7:0]          mask_q, pend, status;
    logic [DEPTH*8-1:0]  rbuf;
    logic [LEN_W-1:0]    len;
    logic                cmd_ok, ack_acc, mask_acc;
    logic [SCNT_W-1:0]   ld_cnt;
    logic [NBYTES*8-1:0] ld_data;

    // Command qualification: correct opcode, exact length, stream idle.
    always_comb begin
        cmd_ok   = cmd_vld_i && !rsp_vld_o;
        ack_acc  = cmd_ok && cmd_op_i == OP_ACK  && cmd_argc_i == 2'd0;
        mask_acc = cmd_ok && cmd_op_i == OP_MASK && cmd_argc_i == 2'd1;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= MASK_RST;
        else if (mask_acc) mask_q <= cmd_arg_i;
    end

    // Acknowledge snapshot: reply-first priority.
    always_comb begin
        if (pend[BIT_INPUT]) begin
            status = pend & INPUT_GRP;
            ld_cnt = SCNT_W'(len) + SCNT_W'(1);
        end else begin
            status = pend;
            ld_cnt = SCNT_W'(1);
        end
        ld_data = {rbuf, status};
    end

    evt_pending #(.DEPTH(DEPTH)) u_pend (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .rply_vld_i(rply_vld_i), .rply_auto_i(rply_auto_i),
        .rply_len_i(rply_len_i), .rply_data_i(rply_data_i),
        .ack_i(ack_acc), .pend_o(pend), .rbuf_o(rbuf), .len_o(len)
    );

    evt_rsp_stream #(.NBYTES(NBYTES)) u_stream (
        .clk(clk), .rst_n(rst_n), .load_i(ack_acc),
        .load_data_i(ld_data), .load_cnt_i(ld_cnt),
        .vld_o(rsp_vld_o), .data_o(rsp_data_o), .last_o(rsp_last_o)
    );

    evt_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
        .clk(clk), .rst_n(rst_n), .mask_wr_i(poll_mask_wr_i),
        .mask_i(poll_mask_i), .hold_i(pend[BIT_INPUT]),
        .poll_req_o(poll_req_o), .mask_o(poll_mask_o)
    );

    assign irq_n_o = ~|(pend & mask_q);

    // R1
    mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_acc && cmd_arg_i == 8'h00) |=> irq_n_o);
    // R6
    bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_i && cmd_op_i == OP_MASK && cmd_argc_i != 2'd1) |=> $stable(mask_q));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_i && rsp_vld_o) |=> $stable(mask_q));
endmodule

// File: tb/tb_evt_irq_unit.sv
module tb_evt_irq_unit;
    localparam int DEPTH = 16;
    localparam int P     = 20;
    localparam int LEN_W = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick = 0, rvld = 0, rauto = 0, cvld = 0, pmwr = 0;
    logic [LEN_W-1:0] rlen = '0;
    logic [DEPTH*8-1:0] rdata = '0;
    logic [7:0] cop = 0, carg = 0;
    logic [1:0] cargc = 0;
    logic [15:0] pmask = 0;
    logic irq_n, rsp_vld, rsp_last, poll_req;
    logic [7:0] rsp_data;
    logic [15:0] pmask_o;

    int checks = 0, errors = 0, cyc = 0;
    logic [8:0] expq[$];
    logic [8:0] e;

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    evt_irq_unit #(.DEPTH(DEPTH), .POLL_CYCLES(P)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rply_vld_i(rvld),
        .rply_auto_i(rauto), .rply_len_i(rlen), .rply_data_i(rdata),
        .cmd_vld_i(cvld), .cmd_op_i(cop), .cmd_argc_i(cargc), .cmd_arg_i(carg),
        .poll_mask_wr_i(pmwr), .poll_mask_i(pmask), .irq_n_o(irq_n),
        .rsp_vld_o(rsp_vld), .rsp_data_o(rsp_data), .rsp_last_o(rsp_last),
        .poll_req_o(poll_req), .poll_mask_o(pmask_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every stream byte is popped and compared.
    always @(negedge clk) begin
        if (rst_n && rsp_vld) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected byte act=%h exp=none", rsp_data);
            end else begin
                e = expq.pop_front();
                if ({rsp_last, rsp_data} !== e) begin
                    errors++;
                    $display("FAIL R7/R8 stream act=%h exp=%h", {rsp_last, rsp_data}, e);
                end
            end
        end
    end

    task automatic push(input logic [7:0] b, input logic last);
        expq.push_back({last, b});
    endtask

    task automatic cmd(input logic [7:0] op, input logic [1:0] argc, input logic [7:0] arg);
        cvld = 1; cop = op; cargc = argc; carg = arg;
        @(negedge clk);
        cvld = 0;
    endtask

    task automatic ack();
        cmd(8'h20, 2'd0, 8'h00);
    endtask

    task automatic wait_idle();
        while (rsp_vld) @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1; @(negedge clk); tick = 0;
    endtask

    task automatic reply(input logic au, input int len);
        rvld = 1; rauto = au; rlen = LEN_W'(len);
        @(negedge clk);
        rvld = 0; rauto = 0;
    endtask

    task automatic set_poll(input logic [15:0] m);
        pmwr = 1; pmask = m; @(negedge clk); pmwr = 0;
    endtask

    task automatic wait_poll(input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!poll_req && n < lim);
        if (!poll_req) n = -1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, t1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2 reset state
        chk("R2 irq_n", irq_n, 1);
        chk("R2 rsp_vld", rsp_vld, 0);
        chk("R2 poll_req", poll_req, 0);
        chk("R2 poll_mask", pmask_o, 0);

        // R8 empty acknowledge, R10 first byte next cycle
        push(8'h00, 1); ack();
        chk("R10 first byte timing", rsp_vld, 1);
        wait_idle();

        // R3 tick sets bit 3, R1 line follows
        pulse_tick();
        chk("R3 R1 irq after tick", irq_n, 0);
        push(8'h08, 1); ack(); wait_idle();
        chk("R8 irq after clear", irq_n, 1);

        // R1 mask 0 hides, R6 wrong-length mask writes ignored
        cmd(8'h21, 2'd1, 8'h00);
        pulse_tick();
        chk("R1 masked tick", irq_n, 1);
        cmd(8'h21, 2'd0, 8'h09);
        chk("R6 argc0 mask ignored", irq_n, 1);
        cmd(8'h21, 2'd2, 8'hFF);
        chk("R6 argc2 mask ignored", irq_n, 1);
        cmd(8'h55, 2'd1, 8'hFF);
        chk("R6 unknown opcode ignored", irq_n, 1);
        cmd(8'h21, 2'd1, 8'h08);
        chk("R1 mask 08", irq_n, 0);

        // R6 acknowledge with argument ignored
        cmd(8'h20, 2'd1, 8'h00);
        @(negedge clk);
        chk("R6 bad ack no stream", rsp_vld, 0);
        chk("R6 bad ack keeps flag", irq_n, 0);
        push(8'h08, 1); ack(); wait_idle();
        cmd(8'h21, 2'd1, 8'h09);

        // R4 R7 device reply plus tick
        rdata = '0; rdata[7:0] = 8'hAA; rdata[15:8] = 8'hBB; rdata[23:16] = 8'hCC;
        reply(0, 3);
        pulse_tick();
        chk("R4 irq reply", irq_n, 0);
        push(8'h01, 0); push(8'hAA, 0); push(8'hBB, 0); push(8'hCC, 1);
        ack(); wait_idle();
        chk("R7 tick kept", irq_n, 0);
        push(8'h08, 1); ack(); wait_idle();
        chk("R8 irq clear", irq_n, 1);

        // R5 autopoll reply
        rdata = '0; rdata[7:0] = 8'hD0; rdata[15:8] = 8'hD1;
        reply(1, 2);
        chk("R5 autopoll irq", irq_n, 0);
        push(8'h05, 0); push(8'hD0, 0); push(8'hD1, 1);
        ack(); wait_idle();
        chk("R7 irq after reply ack", irq_n, 1);

        // R5 zero-length autopoll rejected
        reply(1, 0);
        chk("R5 zero len irq", irq_n, 1);
        push(8'h00, 1); ack(); wait_idle();

        // R5 autopoll rejected while reply pending
        rdata = '0; rdata[7:0] = 8'h11;
        reply(0, 1);
        rdata = '0; rdata[7:0] = 8'h22; rdata[15:8] = 8'h33;
        reply(1, 2);
        push(8'h01, 0); push(8'h11, 1);
        ack(); wait_idle();

        // R1 mask sweep on pending 0x05
        rdata = '0; rdata[7:0] = 8'h44;
        reply(1, 1);
        cmd(8'h21, 2'd1, 8'h04);
        chk("R1 mask 04", irq_n, 0);
        cmd(8'h21, 2'd1, 8'h08);
        chk("R1 mask 08 none", irq_n, 1);
        cmd(8'h21, 2'd1, 8'h01);
        chk("R1 mask 01", irq_n, 0);
        cmd(8'h21, 2'd1, 8'h09);
        push(8'h05, 0); push(8'h44, 1);
        ack(); wait_idle();

        // R9 tick in the acknowledge cycle survives
        push(8'h00, 1);
        tick = 1; cvld = 1; cop = 8'h20; cargc = 0;
        @(negedge clk);
        tick = 0; cvld = 0;
        wait_idle();
        chk("R9 tick survives", irq_n, 0);
        push(8'h08, 1); ack(); wait_idle();

        // R9 reply in the acknowledge cycle survives with new buffer
        rdata = '0; rdata[7:0] = 8'h55;
        reply(0, 1);
        push(8'h01, 0); push(8'h55, 1);
        rdata = '0; rdata[7:0] = 8'h66;
        rvld = 1; rauto = 0; rlen = 1; cvld = 1; cop = 8'h20; cargc = 0;
        @(negedge clk);
        rvld = 0; cvld = 0;
        wait_idle();
        chk("R9 reply survives", irq_n, 0);
        push(8'h01, 0); push(8'h66, 1);
        ack(); wait_idle();

        // R4 length clamp, full stream, R10 commands ignored while busy
        for (int i = 0; i < DEPTH; i++) rdata[i*8 +: 8] = 8'(i * 3 + 1);
        reply(0, 20);
        push(8'h01, 0);
        for (int i = 0; i < DEPTH; i++) push(8'(i * 3 + 1), i == DEPTH - 1);
        ack();
        @(negedge clk);
        cmd(8'h21, 2'd1, 8'h00);
        wait_idle();
        pulse_tick();
        chk("R10 busy mask ignored", irq_n, 0);
        push(8'h08, 1); ack(); wait_idle();

        // R11 poll timing
        set_poll(16'h1234);
        chk("R11 poll mask out", pmask_o, 16'h1234);
        wait_poll(100, n);
        chk("R11 first interval", n, P);
        t1 = cyc;
        repeat (6) @(negedge clk);
        set_poll(16'h1234);
        wait_poll(100, n);
        chk("R11 same value no restart", cyc - t1, P);
        set_poll(16'h0001);
        wait_poll(100, n);
        chk("R11 new value restart", n, P);
        set_poll(16'h0000);
        wait_poll(3 * P, n);
        chk("R11 stopped", n, -1);
        rdata = '0; rdata[7:0] = 8'h77;
        reply(0, 1);
        set_poll(16'h00FF);
        wait_poll(3 * P, n);
        chk("R11 held while reply pending", n, -1);
        push(8'h01, 0); push(8'h77, 1);
        ack(); wait_idle();
        wait_poll(2 * P, n);
        chk("R11 resumes", n > 0, 1);
        set_poll(16'h0000);

        repeat (3) @(negedge clk);
        chk("R10 drained", expq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule